// File: doc/BRIEF.md
# Write Burst Disconnect Controller

This block sits in the target side of a bus bridge and decides, for each data phase of an incoming write burst, whether the bridge takes the DWORD and whether it ends the burst with a disconnect at that phase. An address phase (`start_i`) loads the starting DWORD address and the write kind. On each later cycle where the initiator offers data, the block weighs the write kind, the programmed cache line size in DWORDs, a disconnect-control configuration bit and the free DWORD count of the posted write buffer. It then raises `accept_o`, `disc_o`, or both, in the same cycle.

A disconnect is signalled together with the last DWORD taken, so that phase completes and the burst is closed. The one exception is a posted write that finds the buffer already full, which disconnects with no data taken. The block keeps the running burst address and advances it by one for each DWORD taken. It leaves buffer storage, address decode and bus handshake timing to its neighbours.

Top module: `wr_disc_ctrl`

## Requirements
- R1: After reset `active_o`, `accept_o` and `disc_o` are 0 and `cur_addr_o` is 0.
- R2: A cycle with `start_i` high loads `start_addr_i` into `cur_addr_o` and sets `active_o` from the next cycle. `data_i` is ignored in that cycle. Without `data_i`, `accept_o` and `disc_o` stay 0.
- R3: Kind code 2'b00 (delayed write) and code 2'b11 (treated the same way) accept the first data phase with `disc_o` high, whatever the buffer space.
- R4: Kind 2'b01 (posted memory write) with `disc_ctl_i` = 0 disconnects on the DWORD whose address bits [9:0] are all ones, which is the last DWORD before a 4 KB boundary.
- R5: Kind 2'b01 with `disc_ctl_i` = 1 and a cache line size of 1, 2, 4, 8 or 16 also disconnects on the last DWORD of a line, where (address mod size) = size-1. With any other size only the 4 KB rule applies.
- R6: Kind 2'b10 (memory write and invalidate) with a cache line size not in {1,2,4,8,16} disconnects only at the 4 KB boundary, apart from the buffer rule in R8.
- R7: Kind 2'b10 with a valid cache line size disconnects on the last DWORD of a line only when `free_dw_i` - 1 is less than the line size, meaning the buffer has no room for another full line. It always disconnects at the 4 KB boundary.
- R8: For posted kinds (2'b01, 2'b10) a data phase is accepted while `free_dw_i` >= 1. When `free_dw_i` = 1 the phase is accepted with `disc_o`. When `free_dw_i` = 0, `accept_o` = 0 and `disc_o` = 1.
- R9: `cur_addr_o` advances by one on each accepted phase and holds otherwise. With no active burst, `data_i` has no effect on any output.
- R10: After a cycle with `disc_o` high, `active_o` is 0 and further `data_i` is ignored until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Address phase of a new write burst |
| start_addr_i | input | ADDR_W | Starting DWORD address |
| kind_i | input | 2 | Write kind: 00 delayed, 01 posted, 10 write-and-invalidate, 11 as delayed |
| data_i | input | 1 | Initiator offers a data phase this cycle |
| cls_i | input | CLS_W | Cache line size in DWORDs |
| disc_ctl_i | input | 1 | Disconnect at cache line boundaries for posted writes |
| free_dw_i | input | FREE_W | Free DWORDs in the posted write buffer |
| accept_o | output | 1 | Data phase is taken |
| disc_o | output | 1 | Disconnect at this phase |
| active_o | output | 1 | Burst is open |
| cur_addr_o | output | ADDR_W | DWORD address of the current data phase |

## Verification
`accept_o` and `disc_o` depend combinationally on the registered burst state and the current inputs, so they are due in the same cycle the inputs are applied. `cur_addr_o` and `active_o` change one clock edge after a start, an accepted phase or a disconnect. The bench drives inputs 1 ns after the rising edge and samples every output at the falling edge. A behavioural model compares all four results on every cycle, and it advances its own state only after that comparison, so it matches the register update at the next rising edge.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  typedef enum logic [1:0] {
    WK_DLY = 2'b00,
    WK_PMW = 2'b01,
    WK_MWI = 2'b10,
    WK_RSV = 2'b11
  } wr_kind_e;
endpackage

// File: rtl/wdc_burst_trk.sv
module wdc_burst_trk
  import wdc_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  wr_kind_e          kind_i,
  input  logic              adv_i,
  input  logic              stop_i,
  output logic              active_o,
  output wr_kind_e          kind_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      kind_o   <= WK_DLY;
      addr_o   <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      kind_o   <= kind_i;
      addr_o   <= start_addr_i;
    end else begin
      if (adv_i)  addr_o   <= addr_o + ADDR_W'(1);
      if (stop_i) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdc_bound_det.sv
module wdc_bound_det #(
  parameter int PAGE_W  = 10,
  parameter int CLS_W   = 5,
  parameter int MAX_CLS = 16
) (
  input  logic [PAGE_W-1:0] addr_i,
  input  logic [CLS_W-1:0]  cls_i,
  output logic              line_end_o,
  output logic              page_end_o,
  output logic              cls_ok_o
);
  logic [CLS_W-1:0] cls_m1;

  assign cls_m1     = cls_i - CLS_W'(1);
  // size must be a power of two no larger than MAX_CLS
  assign cls_ok_o   = (cls_i != '0) && ((cls_i & cls_m1) == '0) && (cls_i <= CLS_W'(MAX_CLS));
  assign line_end_o = (addr_i[CLS_W-1:0] & cls_m1) == cls_m1;
  assign page_end_o = &addr_i;
endmodule

// File: rtl/wr_disc_ctrl.sv
module wr_disc_ctrl
  import wdc_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int FREE_W  = 8,
  parameter int CLS_W   = 5,
  parameter int PAGE_W  = 10,
  parameter int MAX_CLS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        kind_i,
  input  logic              data_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              disc_ctl_i,
  input  logic [FREE_W-1:0] free_dw_i,
  output logic              accept_o,
  output logic              disc_o,
  output logic              active_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int CMP_W = FREE_W + 1;

  wr_kind_e kind_q;
  logic     line_end, page_end, cls_ok;
  logic     phase, posted, short_room, bound_hit;

  wdc_burst_trk #(.ADDR_W(ADDR_W)) trk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .kind_i       (wr_kind_e'(kind_i)),
    .adv_i        (accept_o),
    .stop_i       (disc_o),
    .active_o     (active_o),
    .kind_o       (kind_q),
    .addr_o       (cur_addr_o)
  );

  wdc_bound_det #(.PAGE_W(PAGE_W), .CLS_W(CLS_W), .MAX_CLS(MAX_CLS)) bnd_i (
    .addr_i     (cur_addr_o[PAGE_W-1:0]),
    .cls_i      (cls_i),
    .line_end_o (line_end),
    .page_end_o (page_end),
    .cls_ok_o   (cls_ok)
  );

  assign phase  = active_o && data_i && !start_i;
  assign posted = (kind_q == WK_PMW) || (kind_q == WK_MWI);
  // after this DWORD fewer than a full line of space remains
  assign short_room = CMP_W'(free_dw_i) <= CMP_W'(cls_i);

  assign bound_hit = page_end
                   || (line_end && cls_ok &&
                       (((kind_q == WK_PMW) && disc_ctl_i) ||
                        ((kind_q == WK_MWI) && short_room)));

  always_comb begin
    accept_o = 1'b0;
    disc_o   = 1'b0;
    if (phase) begin
      if (!posted) begin
        accept_o = 1'b1;
        disc_o   = 1'b1;
      end else if (free_dw_i == '0) begin
        disc_o   = 1'b1;
      end else begin
        accept_o = 1'b1;
        disc_o   = (free_dw_i == FREE_W'(1)) || bound_hit;
      end
    end
  end
endmodule

// File: rtl/wdc_chk.sv
module wdc_chk #(
  parameter int ADDR_W = 30,
  parameter int FREE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              data_i,
  input logic [FREE_W-1:0] free_dw_i,
  input logic [1:0]        kind_q,
  input logic              accept_o,
  input logic              disc_o,
  input logic              active_o,
  input logic [ADDR_W-1:0] cur_addr_o
);
  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o && (cur_addr_o == $past(start_addr_i)));

  // R9
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> cur_addr_o == $past(cur_addr_o) + ADDR_W'(1));

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !accept_o) |=> $stable(cur_addr_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !accept_o && !disc_o);

  // R10
  end_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_o |=> !active_o);

  // R8
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && data_i && !start_i && (kind_q == 2'b01 || kind_q == 2'b10) && free_dw_i == '0)
      |-> !accept_o && disc_o);

  // R3
  dly_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && (kind_q == 2'b00 || kind_q == 2'b11)) |-> disc_o);
endmodule

bind wr_disc_ctrl wdc_chk #(.ADDR_W(ADDR_W), .FREE_W(FREE_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .data_i       (data_i),
  .free_dw_i    (free_dw_i),
  .kind_q       (kind_q),
  .accept_o     (accept_o),
  .disc_o       (disc_o),
  .active_o     (active_o),
  .cur_addr_o   (cur_addr_o)
);

// File: tb/wr_disc_ctrl_tb_top.sv
module wr_disc_ctrl_tb_top;
  localparam int ADDR_W = 30;
  localparam int FREE_W = 8;
  localparam int CLS_W  = 5;
  localparam longint AMASK = (64'd1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [1:0]        kind_i = 2'b00;
  logic              data_i = 1'b0;
  logic [CLS_W-1:0]  cls_i = 5'd8;
  logic              disc_ctl_i = 1'b0;
  logic [FREE_W-1:0] free_dw_i = 8'd100;
  logic              accept_o, disc_o, active_o;
  logic [ADDR_W-1:0] cur_addr_o;

  always #2 clk = ~clk;

  wr_disc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_addr_i(start_addr_i),
    .kind_i(kind_i), .data_i(data_i), .cls_i(cls_i), .disc_ctl_i(disc_ctl_i),
    .free_dw_i(free_dw_i), .accept_o(accept_o), .disc_o(disc_o),
    .active_o(active_o), .cur_addr_o(cur_addr_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  bit     m_act = 0;
  int     m_kind = 0;
  longint m_addr = 0;

  task automatic cmp1(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit cls_valid(int c);
    return c == 1 || c == 2 || c == 4 || c == 8 || c == 16;
  endfunction

  // behavioural reference, compared every falling edge
  always @(negedge clk) begin
    bit e_acc, e_disc, fin;
    int c, f;
    e_acc = 0; e_disc = 0;
    if (!rst_ni) begin
      m_act = 0; m_addr = 0; m_kind = 0;
    end else if (m_act && data_i && !start_i) begin
      c = int'(cls_i); f = int'(free_dw_i);
      if (m_kind == 0 || m_kind == 3) begin
        e_acc = 1; e_disc = 1;
      end else if (f == 0) begin
        e_disc = 1;
      end else begin
        e_acc = 1;
        fin = (f == 1) || ((m_addr % 1024) == 1023);
        if (cls_valid(c) && (m_addr % c) == c - 1) begin
          if (m_kind == 1 && disc_ctl_i) fin = 1;
          if (m_kind == 2 && (f - 1) < c) fin = 1;
        end
        e_disc = fin;
      end
    end
    cmp1("accept_o", accept_o, e_acc);
    cmp1("disc_o", disc_o, e_disc);
    cmp1("active_o", active_o, m_act);
    cmp1("cur_addr_o", cur_addr_o, m_addr);
    if (rst_ni) begin
      if (start_i) begin
        m_act = 1; m_addr = start_addr_i; m_kind = int'(kind_i);
      end else begin
        if (e_acc) m_addr = (m_addr + 1) & AMASK;
        if (e_disc) m_act = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic go(int k, longint a);
    start_i = 1; kind_i = 2'(k); start_addr_i = ADDR_W'(a); data_i = 0;
    step();
    start_i = 0;
  endtask

  task automatic ph(bit d, int f);
    data_i = d; free_dw_i = FREE_W'(f);
    step();
    data_i = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1;
    tag = "R1"; step();

    tag = "R2"; go(1, 30'h155); ph(0, 50); ph(0, 50);
    start_i = 1; data_i = 1; kind_i = 2'b01; start_addr_i = 30'h200; step(); start_i = 0; data_i = 0;

    tag = "R3"; go(0, 5); ph(1, 0); ph(1, 9); ph(1, 9);
    go(3, 7); ph(1, 3); ph(1, 3);

    tag = "R4"; disc_ctl_i = 0; cls_i = 5'd8;
    go(1, 30'h3FC); for (int i = 0; i < 6; i++) ph(1, 100);

    tag = "R5"; disc_ctl_i = 1; cls_i = 5'd8;
    go(1, 30'h13); for (int i = 0; i < 7; i++) ph(1, 100);
    cls_i = 5'd3; go(1, 30'h3FB); for (int i = 0; i < 6; i++) ph(1, 100);
    cls_i = 5'd16; go(1, 30'h2E); for (int i = 0; i < 4; i++) ph(1, 100);

    tag = "R6"; disc_ctl_i = 1; cls_i = 5'd6;
    go(2, 30'h7F8); for (int i = 0; i < 10; i++) ph(1, 3);

    tag = "R7"; disc_ctl_i = 0; cls_i = 5'd4;
    go(2, 30'h10); for (int i = 0; i < 7; i++) ph(1, 100);
    ph(1, 5); ph(1, 5); ph(1, 5); ph(1, 4); ph(1, 4);
    go(2, 30'hFFC); for (int i = 0; i < 6; i++) ph(1, 100);

    tag = "R8"; go(1, 30'h40); ph(1, 10); ph(1, 0); ph(1, 10);
    go(2, 30'h50); ph(1, 3); ph(1, 2); ph(1, 1); ph(1, 1);

    tag = "R9"; go(1, 30'h3FFFFFFE); ph(1, 80); ph(0, 80); ph(0, 80); ph(1, 80); ph(1, 80);
    ph(1, 80); ph(1, 80);

    tag = "R10"; go(1, 30'h3FF); ph(1, 50); ph(1, 50); ph(1, 50);

    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      start_i = ($urandom_range(0, 9) == 0);
      kind_i = 2'($urandom_range(0, 3));
      start_addr_i = ADDR_W'($urandom_range(0, 4095));
      data_i = ($urandom_range(0, 3) != 0);
      cls_i = CLS_W'($urandom_range(1, 17));
      disc_ctl_i = 1'($urandom_range(0, 1));
      free_dw_i = FREE_W'($urandom_range(0, 24));
      step();
    end
    start_i = 0; data_i = 0; step(); step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s: actual hung expected finished", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule